// File: doc/BRIEF.md
# Multi-Size Translation Cache with Overlap Abort

A small fully associative translation cache that holds both 4KB and 2MB page mappings. Every lookup compares the virtual address, address space identifier, security state and exception level against all valid entries in parallel. The result is registered and appears one cycle after the request. Exactly one match returns a physical address, no match returns a miss, and two or more matches raise an overlap abort.

Multiple matches arise when stale entries are never cleaned up. A small-page entry can remain after the tables were changed to a large-page mapping, and a later walk then loads the large page alongside it. Fills from the external walker are written without any check for overlap, so the block can detect this situation instead of hiding it.

The abort can be switched off. In that case the lowest-index matching entry supplies the translation. Entries are removed by an invalidate-all strobe or by an invalidate-by-ASID strobe, and both take effect in one cycle.

Top module: `msz_tlb`

## Requirements
- R1: A 4KB entry (fill_big_i=0) matches when lookup VA bits [47:12] equal the filled VA bits [47:12]; the returned PA is fill PA bits [39:12] followed by lookup VA bits [11:0].
- R2: A 2MB entry (fill_big_i=1) matches when lookup VA bits [47:21] equal the filled VA bits [47:21]; the returned PA is fill PA bits [39:21] followed by lookup VA bits [20:0].
- R3: A match also needs equal secure flag and equal exception level. The ASID must also be equal when the entry's non-global flag is 1; an entry with the flag at 0 matches any ASID.
- R4: For every cycle with lkp_req_i=1, rsp_valid_o is 1 in the following cycle and 0 after a cycle without a request. At most one of hit, miss and conflict is 1, and a lookup with no matching entry gives miss=1 and pa=0.
- R5: A fill is written without checking for or removing overlapping entries, so a 4KB entry and a 2MB entry covering the same address coexist.
- R6: With conflict_en_i=1 and two or more matches, the response has conflict=1, hit=0, miss=0 and pa=0.
- R7: With conflict_en_i=0 and two or more matches, the response is a hit carrying the PA of the lowest-index matching entry.
- R8: A fill goes to the lowest-index invalid entry if one exists. Otherwise it goes to a replacement pointer that starts at 0 after reset and advances by one, wrapping after 7, on each fill that replaces a valid entry.
- R9: inv_all_i clears every entry in one cycle, so a lookup in the next cycle misses.
- R10: inv_asid_i clears every entry whose non-global flag is 1 and whose ASID equals inv_asid_val_i; global entries and entries of other ASIDs stay.
- R11: After reset every entry is invalid and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conflict_en_i | input | 1 | 1 = report multiple matches as an abort |
| lkp_req_i | input | 1 | Lookup request |
| lkp_va_i | input | 48 | Lookup virtual address |
| lkp_asid_i | input | 8 | Lookup ASID |
| lkp_el_i | input | 2 | Lookup exception level |
| lkp_ns_i | input | 1 | Lookup security state, 1 = non-secure |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_hit_o | output | 1 | Single translation found |
| rsp_miss_o | output | 1 | No entry matched |
| rsp_conflict_o | output | 1 | Overlap abort |
| rsp_pa_o | output | 40 | Physical address on a hit, else 0 |
| fill_i | input | 1 | Write a new translation |
| fill_big_i | input | 1 | 1 = 2MB page, 0 = 4KB page |
| fill_va_i | input | 48 | Fill virtual address |
| fill_pa_i | input | 40 | Fill physical address |
| fill_asid_i | input | 8 | Fill ASID |
| fill_ng_i | input | 1 | Fill non-global flag |
| fill_ns_i | input | 1 | Fill security state |
| fill_el_i | input | 2 | Fill exception level |
| inv_all_i | input | 1 | Invalidate every entry |
| inv_asid_i | input | 1 | Invalidate non-global entries of one ASID |
| inv_asid_val_i | input | 8 | ASID to invalidate |

## Verification
A lookup request driven before a rising edge yields its response on the registered outputs just after that edge. The bench therefore drives each request on a falling edge and compares all four result fields on the next falling edge, where the response belongs to exactly that request. Fills and invalidations update entries on the same edge, so a lookup driven on the following falling edge already sees the new contents. The expected result comes from a bench model of the matching, sizing and replacement rules, after each write or invalidate.

// File: rtl/msz_tlb_pkg.sv
package msz_tlb_pkg;
  localparam int unsigned OFF_SMALL = 12;
  localparam int unsigned OFF_LARGE = 21;
  typedef enum logic [1:0] {RES_NONE, RES_HIT, RES_MISS, RES_CONFLICT} res_e;
endpackage

// File: rtl/msz_tlb_entry.sv
module msz_tlb_entry
  import msz_tlb_pkg::*;
#(
  parameter int unsigned VA_W   = 48,
  parameter int unsigned PA_W   = 40,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned EL_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_big_i,
  input  logic [VA_W-1:0]   wr_va_i,
  input  logic [PA_W-1:0]   wr_pa_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_ng_i,
  input  logic              wr_ns_i,
  input  logic [EL_W-1:0]   wr_el_i,
  input  logic              inv_all_i,
  input  logic              inv_asid_i,
  input  logic [ASID_W-1:0] inv_asid_val_i,
  input  logic [VA_W-1:0]   lkp_va_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  input  logic [EL_W-1:0]   lkp_el_i,
  input  logic              lkp_ns_i,
  output logic              valid_o,
  output logic              match_o,
  output logic [PA_W-1:0]   pa_o
);
  logic                      vld_q, big_q, ng_q, ns_q;
  logic [EL_W-1:0]           el_q;
  logic [ASID_W-1:0]         asid_q;
  logic [VA_W-1:OFF_SMALL]   vtag_q;
  logic [PA_W-1:OFF_SMALL]   ptag_q;
  logic                      kill_asid;

  assign kill_asid = inv_asid_i && ng_q && (asid_q == inv_asid_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      big_q  <= 1'b0;
      ng_q   <= 1'b0;
      ns_q   <= 1'b0;
      el_q   <= '0;
      asid_q <= '0;
      vtag_q <= '0;
      ptag_q <= '0;
    end else if (wr_i) begin
      vld_q  <= 1'b1;
      big_q  <= wr_big_i;
      ng_q   <= wr_ng_i;
      ns_q   <= wr_ns_i;
      el_q   <= wr_el_i;
      asid_q <= wr_asid_i;
      vtag_q <= wr_va_i[VA_W-1:OFF_SMALL];
      ptag_q <= wr_pa_i[PA_W-1:OFF_SMALL];
    end else if (inv_all_i || kill_asid) begin
      vld_q  <= 1'b0;
    end
  end

  logic tag_ok, va_ok;
  assign tag_ok = (ns_q == lkp_ns_i) && (el_q == lkp_el_i) &&
                  (!ng_q || (asid_q == lkp_asid_i));
  assign va_ok  = big_q ? (vtag_q[VA_W-1:OFF_LARGE] == lkp_va_i[VA_W-1:OFF_LARGE])
                        : (vtag_q == lkp_va_i[VA_W-1:OFF_SMALL]);

  assign valid_o = vld_q;
  assign match_o = vld_q && tag_ok && va_ok;
  assign pa_o    = big_q ? {ptag_q[PA_W-1:OFF_LARGE], lkp_va_i[OFF_LARGE-1:0]}
                         : {ptag_q, lkp_va_i[OFF_SMALL-1:0]};

  a_r9_inv_all_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && !wr_i) |=> !vld_q);
  a_r10_asid_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_asid_i && !wr_i && ng_q && asid_q == inv_asid_val_i) |=> !vld_q);
  a_r10_global_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_asid_i && !inv_all_i && !wr_i && !ng_q) |=> $stable(vld_q));
endmodule

// File: rtl/msz_tlb_victim.sv
module msz_tlb_victim #(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] valid_i,
  input  logic             fill_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] rr_q, free_idx;
  logic             any_free;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign idx_o = any_free ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (fill_i && !any_free)
      rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
  end

  a_r8_free_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !(&valid_i)) |-> !valid_i[idx_o]);
  a_r8_ptr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !(&valid_i)) |=> $stable(rr_q));
endmodule

// File: rtl/msz_tlb_resolve.sv
module msz_tlb_resolve
  import msz_tlb_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned PA_W  = 40
) (
  input  logic [N_ENT-1:0] match_i,
  input  logic [PA_W-1:0]  pa_i [N_ENT],
  input  logic             conflict_en_i,
  output res_e             res_o,
  output logic [PA_W-1:0]  pa_o
);
  logic [PA_W-1:0] first_pa;
  logic            multi;

  always_comb begin
    first_pa = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (match_i[i]) first_pa = pa_i[i];
  end

  assign multi = $countones(match_i) > 1;

  always_comb begin
    if (match_i == '0) begin
      res_o = RES_MISS;
      pa_o  = '0;
    end else if (multi && conflict_en_i) begin
      res_o = RES_CONFLICT;
      pa_o  = '0;
    end else begin
      res_o = RES_HIT;
      pa_o  = first_pa;
    end
  end
endmodule

// File: rtl/msz_tlb.sv
module msz_tlb
  import msz_tlb_pkg::*;
#(
  parameter int unsigned N_ENT  = 8,
  parameter int unsigned VA_W   = 48,
  parameter int unsigned PA_W   = 40,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned EL_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conflict_en_i,
  input  logic              lkp_req_i,
  input  logic [VA_W-1:0]   lkp_va_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  input  logic [EL_W-1:0]   lkp_el_i,
  input  logic              lkp_ns_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic              rsp_conflict_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  input  logic              fill_i,
  input  logic              fill_big_i,
  input  logic [VA_W-1:0]   fill_va_i,
  input  logic [PA_W-1:0]   fill_pa_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_ng_i,
  input  logic              fill_ns_i,
  input  logic [EL_W-1:0]   fill_el_i,
  input  logic              inv_all_i,
  input  logic              inv_asid_i,
  input  logic [ASID_W-1:0] inv_asid_val_i
);
  localparam int unsigned IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0] ent_vld, ent_match;
  logic [PA_W-1:0]  ent_pa [N_ENT];
  logic [IDX_W-1:0] vic_idx;
  res_e             res;
  logic [PA_W-1:0]  res_pa;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    msz_tlb_entry #(
      .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .EL_W(EL_W)
    ) u_ent (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_i           (fill_i && (vic_idx == IDX_W'(g))),
      .wr_big_i       (fill_big_i),
      .wr_va_i        (fill_va_i),
      .wr_pa_i        (fill_pa_i),
      .wr_asid_i      (fill_asid_i),
      .wr_ng_i        (fill_ng_i),
      .wr_ns_i        (fill_ns_i),
      .wr_el_i        (fill_el_i),
      .inv_all_i      (inv_all_i),
      .inv_asid_i     (inv_asid_i),
      .inv_asid_val_i (inv_asid_val_i),
      .lkp_va_i       (lkp_va_i),
      .lkp_asid_i     (lkp_asid_i),
      .lkp_el_i       (lkp_el_i),
      .lkp_ns_i       (lkp_ns_i),
      .valid_o        (ent_vld[g]),
      .match_o        (ent_match[g]),
      .pa_o           (ent_pa[g])
    );
  end

  msz_tlb_victim #(.N_ENT(N_ENT)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (ent_vld),
    .fill_i  (fill_i),
    .idx_o   (vic_idx)
  );

  msz_tlb_resolve #(.N_ENT(N_ENT), .PA_W(PA_W)) u_resolve (
    .match_i       (ent_match),
    .pa_i          (ent_pa),
    .conflict_en_i (conflict_en_i),
    .res_o         (res),
    .pa_o          (res_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_hit_o      <= 1'b0;
      rsp_miss_o     <= 1'b0;
      rsp_conflict_o <= 1'b0;
      rsp_pa_o       <= '0;
    end else begin
      rsp_valid_o    <= lkp_req_i;
      rsp_hit_o      <= lkp_req_i && (res == RES_HIT);
      rsp_miss_o     <= lkp_req_i && (res == RES_MISS);
      rsp_conflict_o <= lkp_req_i && (res == RES_CONFLICT);
      rsp_pa_o       <= lkp_req_i ? res_pa : '0;
    end
  end

  a_r4_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_hit_o, rsp_miss_o, rsp_conflict_o}));
  a_r4_resp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_i |=> rsp_valid_o);
  a_r4_no_resp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_req_i |=> !rsp_valid_o);
  a_r6_abort_no_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_conflict_o |-> (rsp_pa_o == '0));
  a_r7_abort_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_req_i && !conflict_en_i) |=> !rsp_conflict_o);
  a_r6_abort_needs_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_req_i && $countones(ent_match) < 2) |=> !rsp_conflict_o);
endmodule

// File: tb/msz_tlb_bench.sv
`timescale 1ns/1ps
module msz_tlb_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        conflict_en_i = 1'b1;
  logic        lkp_req_i = 1'b0;
  logic [47:0] lkp_va_i = '0;
  logic [7:0]  lkp_asid_i = '0;
  logic [1:0]  lkp_el_i = '0;
  logic        lkp_ns_i = 1'b0;
  logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_conflict_o;
  logic [39:0] rsp_pa_o;
  logic        fill_i = 1'b0, fill_big_i = 1'b0, fill_ng_i = 1'b0, fill_ns_i = 1'b0;
  logic [47:0] fill_va_i = '0;
  logic [39:0] fill_pa_i = '0;
  logic [7:0]  fill_asid_i = '0;
  logic [1:0]  fill_el_i = '0;
  logic        inv_all_i = 1'b0, inv_asid_i = 1'b0;
  logic [7:0]  inv_asid_val_i = '0;

  always #10 clk_i = ~clk_i;

  msz_tlb u_msz_tlb (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // bench model
  bit          m_vld [8];
  bit          m_big [8], m_ng [8], m_ns [8];
  logic [1:0]  m_el [8];
  logic [7:0]  m_asid [8];
  logic [47:0] m_va [8];
  logic [39:0] m_pa [8];
  int          m_rr = 0;

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic fill(bit big, logic [47:0] va, logic [39:0] pa, logic [7:0] asid,
                      bit ng, bit ns, logic [1:0] el);
    int v = -1;
    fill_i = 1; fill_big_i = big; fill_va_i = va; fill_pa_i = pa;
    fill_asid_i = asid; fill_ng_i = ng; fill_ns_i = ns; fill_el_i = el;
    @(negedge clk_i);
    fill_i = 0;
    for (int i = 7; i >= 0; i--) if (!m_vld[i]) v = i;
    if (v < 0) begin v = m_rr; m_rr = (m_rr + 1) % 8; end
    m_vld[v] = 1; m_big[v] = big; m_ng[v] = ng; m_ns[v] = ns;
    m_el[v] = el; m_asid[v] = asid; m_va[v] = va; m_pa[v] = pa;
  endtask

  task automatic inv_all();
    inv_all_i = 1;
    @(negedge clk_i);
    inv_all_i = 0;
    for (int i = 0; i < 8; i++) m_vld[i] = 0;
  endtask

  task automatic inv_asid(logic [7:0] a);
    inv_asid_i = 1; inv_asid_val_i = a;
    @(negedge clk_i);
    inv_asid_i = 0;
    for (int i = 0; i < 8; i++) if (m_ng[i] && m_asid[i] == a) m_vld[i] = 0;
  endtask

  task automatic lookup(string rq, logic [47:0] va, logic [7:0] asid, bit ns, logic [1:0] el);
    int n = 0, first = -1;
    logic [39:0] epa = '0;
    bit eh = 0, em = 0, ec = 0;
    lkp_req_i = 1; lkp_va_i = va; lkp_asid_i = asid; lkp_ns_i = ns; lkp_el_i = el;
    for (int i = 7; i >= 0; i--) begin
      bit vm;
      vm = m_big[i] ? (m_va[i][47:21] == va[47:21]) : (m_va[i][47:12] == va[47:12]);
      if (m_vld[i] && vm && m_ns[i] == ns && m_el[i] == el && (!m_ng[i] || m_asid[i] == asid)) begin
        n++; first = i;
      end
    end
    if (n == 0) em = 1;
    else if (n > 1 && conflict_en_i) ec = 1;
    else begin
      eh = 1;
      epa = m_big[first] ? {m_pa[first][39:21], va[20:0]} : {m_pa[first][39:12], va[11:0]};
    end
    @(negedge clk_i);
    chk(rq, "resp", {rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_conflict_o, rsp_pa_o},
        {1'b1, eh, em, ec, epa});
    lkp_req_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] x;
    x = 48'h0081_8000_0000;
    repeat (2) @(negedge clk_i);
    // R11 reset state
    chk("R11", "resp_after_reset", {rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_conflict_o, rsp_pa_o}, '0);
    rst_ni = 1;
    @(negedge clk_i);
    lookup("R11", x, 8'd0, 1, 2'd2);
    // R4 no response after idle cycle
    @(negedge clk_i);
    chk("R4", "idle_valid", rsp_valid_o, 0);

    // R1 small page
    fill(0, x, 40'h12_3450_0000, 8'd1, 1, 1, 2'd2);
    lookup("R1", x, 8'd1, 1, 2'd2);
    lookup("R1", x + 48'h0abc, 8'd1, 1, 2'd2);
    lookup("R4", x + 48'h1000, 8'd1, 1, 2'd2);
    // R3 tag mismatches
    lookup("R3", x, 8'd2, 1, 2'd2);
    lookup("R3", x, 8'd1, 0, 2'd2);
    lookup("R3", x, 8'd1, 1, 2'd1);

    // R5 stale small page plus new large page covering it
    fill(1, x, 40'h00_7760_0000, 8'd1, 1, 1, 2'd2);
    lookup("R2", x + 48'h1000, 8'd1, 1, 2'd2);
    lookup("R2", x + 48'h1f_fff0, 8'd1, 1, 2'd2);
    lookup("R6", x, 8'd1, 1, 2'd2);
    lookup("R5", x + 48'h0040, 8'd1, 1, 2'd2);
    conflict_en_i = 0;
    lookup("R7", x + 48'h0040, 8'd1, 1, 2'd2);
    conflict_en_i = 1;

    // R3 global entry matches any ASID
    fill(0, 48'h0000_4000_3000, 40'h00_0aaa_b000, 8'd9, 0, 0, 2'd1);
    for (int a = 0; a < 256; a += 37) lookup("R3", 48'h0000_4000_3010, 8'(a), 0, 2'd1);

    // R10 invalidate by ASID
    fill(0, 48'h0000_5000_0000, 40'h00_0bbb_0000, 8'd7, 1, 0, 2'd0);
    inv_asid(8'd1);
    lookup("R10", x, 8'd1, 1, 2'd2);
    lookup("R10", 48'h0000_4000_3010, 8'd1, 0, 2'd1);
    lookup("R10", 48'h0000_5000_0000, 8'd7, 0, 2'd0);

    // R9 invalidate all
    inv_all();
    lookup("R9", 48'h0000_4000_3010, 8'd9, 0, 2'd1);
    lookup("R9", 48'h0000_5000_0000, 8'd7, 0, 2'd0);

    // R8 replacement: fill 12 distinct pages, then look all up
    for (int p = 0; p < 12; p++)
      fill(p[0], 48'h0010_0000_0000 + 48'(p) * 48'h40_0000, 40'h00_2000_0000 + 40'(p) * 40'h20_0000,
           8'd3, 1, 1, 2'd1);
    for (int p = 0; p < 12; p++)
      lookup("R8", 48'h0010_0000_0000 + 48'(p) * 48'h40_0000 + 48'h123, 8'd3, 1, 2'd1);

    // R5 sweep: overlapping mixes of sizes, both conflict modes
    inv_all();
    for (int s = 0; s < 6; s++) begin
      fill(s[0], 48'h0020_0000_0000 + 48'(s) * 48'h1000, 40'h00_3000_0000 + 40'(s) * 40'h40_0000,
           8'd5, s[1], 0, 2'd3);
      for (int o = 0; o < 8; o++) begin
        conflict_en_i = o[0];
        lookup("R5", 48'h0020_0000_0000 + 48'(o) * 48'h1000 + 48'h7, 8'd5, 0, 2'd3);
      end
    end
    conflict_en_i = 1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule